// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the transaction layer of an SMBus device. It sits behind a byte-level I2C target front end, which recognises the device address and reports bus events as one-cycle pulses: a start or repeated start together with its read/write bit, a stop, each received byte, and a master NACK after a read byte. The responder decodes each transaction and maps it onto an internal register file. The file holds eight byte registers, four 16-bit word registers and one block buffer of up to 32 bytes. The responder accepts or rejects every received byte in the same cycle, and it offers the read bytes the front end must shift out.

A command byte latches a register pointer, and later transactions reuse it. Writes are held until the transaction ends, so a bad packet never reaches the registers. Packet error checking uses a CRC-8 that can be enabled while the bus is idle. Received bytes have no back-pressure: `rx_valid` is a single-cycle strobe, and `rx_ack` answers in that same cycle. Read bytes form a valid/ready stream. `tx_valid` with `tx_data` stays asserted and unchanged until the front end pulls the byte with `tx_ready`, and a handshake also means the master acknowledged the previous byte.

Top module: `smbt_target`

## Requirements
- R1: After a start with the write bit (`ev_rd`=0), the first received byte is the command and sets the register pointer. Commands 0x00–0x07 select byte registers, 0x40–0x43 select word registers and 0x80 selects the block buffer. Any other command is NACKed, and the rest of the transaction is ignored.
- R2: A start with the read bit and no command byte returns data from the register selected by the most recent accepted command. The pointer survives across transactions and is 0x00 after reset.
- R3: Word data travels low byte first and then high byte, for both writes and reads.
- R4: A block read returns a count byte followed by that many bytes of the active block. The count is the length of the last committed block write, and it is 0 after reset.
- R5: A block write sends the count right after the command and then the data bytes. A count from 1 to 32 is ACKed. A count of 0 or above 32 is NACKed, and the transaction changes nothing.
- R6: A repeated start with the read bit after a command turns the transaction into a read of the selected register. A write whose data is complete when that repeated start arrives is committed first, so the read returns the new value.
- R7: A write takes effect only at a stop or repeated start that follows complete data. A byte beyond the expected length is NACKed, and the pending write is discarded.
- R8: When `pec_en` is 1, a CRC-8 (polynomial 0x07, initial value 0, MSB first) runs over every transferred byte since the last stop, including the address bytes `{7'h2A, rw}`. A read sends it after its last data byte. A write expects it after its last data byte and NACKs a mismatch.
- R9: A mismatched PEC byte, or a stop that arrives with complete data but no PEC while `pec_en` is 1, discards the write and sets `pec_err`. `pec_err` stays set until reset.
- R10: After a master NACK, `tx_valid` stays low until the next start. While `tx_ready` is low, `tx_valid` and `tx_data` hold. Bytes received during a read are NACKed.
- R11: After reset, `tx_valid` and `pec_err` are 0 and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pec_en | input | 1 | Enables packet error checking; changed only while the bus is idle |
| ev_start | input | 1 | Pulse: start or repeated start addressed to this device |
| ev_rd | input | 1 | Read/write bit that comes with `ev_start` (1 = read) |
| ev_stop | input | 1 | Pulse: stop condition |
| rx_valid | input | 1 | Pulse: a byte was received from the master |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | Same-cycle decision for the received byte (1 = ACK) |
| tx_valid | output | 1 | A read byte is offered |
| tx_data | output | 8 | Offered read byte |
| tx_ready | input | 1 | Front end takes the offered byte |
| mst_nack | input | 1 | Pulse: the master NACKed the last read byte |
| pec_err | output | 1 | Sticky PEC failure flag |

## Verification
A corrupt register pointer has no effect until the next read, where the first byte offered comes from the wrong register. A drifting CRC accumulator can stay hidden through plain transfers. It surfaces at the next PEC byte, either as a wrong trailing read byte or as a correct master PEC that is NACKed with `pec_err` rising. A block bank that flips at the wrong time shows in the count byte of the next block read. The bench predicts every offered byte and every ACK from its own transaction model, so each of these faults is caught within the first transaction that exposes it.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_DEAD
  } smbt_state_e;

  typedef enum logic [1:0] {
    CL_BYTE,
    CL_WORD,
    CL_BLOCK,
    CL_BAD
  } smbt_class_e;

  // One byte of CRC-8, polynomial x^8 + x^2 + x + 1, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/smbt_pec.sv
module smbt_pec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import smbt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (upd) crc <= crc8_step(crc, din);
  end

  AST_PEC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00)); // R8

endmodule

// File: rtl/smbt_regbank.sv
module smbt_regbank #(
  parameter int NB = 8,
  parameter int NW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_b,
  input  logic                wr_w,
  input  logic [BIW-1:0]      b_idx,
  input  logic [WIW-1:0]      w_idx,
  input  logic [15:0]         wdata,
  output logic [7:0]          b_q,
  output logic [15:0]         w_q
);
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1;
  localparam int WIW = (NW > 1) ? $clog2(NW) : 1;

  logic [7:0]  breg [NB];
  logic [15:0] wreg [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) breg[i] <= '0;
    end else if (wr_b) begin
      breg[b_idx] <= wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) wreg[i] <= '0;
    end else if (wr_w) begin
      wreg[w_idx] <= wdata;
    end
  end

  assign b_q = breg[b_idx];
  assign w_q = wreg[w_idx];

  AST_SINGLE_CLASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_b && wr_w)); // R7

endmodule

// File: rtl/smbt_blkbuf.sv
module smbt_blkbuf #(
  parameter int MAXLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic            commit,
  input  logic [LW-1:0]   commit_len,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [LW-1:0]   rd_len
);
  localparam int IW = $clog2(MAXLEN);
  localparam int LW = $clog2(MAXLEN + 1);

  logic act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act <= 1'b0;
    else if (commit) act <= ~act;
  end

  // Two banks: writes fill the idle one, a commit makes it the active one
  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam logic ME = 1'(g);
    logic [7:0]    mem [MAXLEN];
    logic [LW-1:0] len;

    always_ff @(posedge clk) begin
      if (wr_en && (act != ME)) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       len <= '0;
      else if (commit && (act != ME))   len <= commit_len;
    end
  end

  assign rd_data = act ? g_bank[1].mem[rd_idx] : g_bank[0].mem[rd_idx];
  assign rd_len  = act ? g_bank[1].len : g_bank[0].len;

  AST_COMMIT_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_len != '0 && commit_len <= LW'(MAXLEN))); // R5

  AST_ACTIVE_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rd_len)); // R4

endmodule

// File: rtl/smbt_target.sv
module smbt_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NB       = 8,
  parameter int         NW       = 4,
  parameter int         BLK_MAX  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pec_en,
  input  logic       ev_start,
  input  logic       ev_rd,
  input  logic       ev_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ack,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       mst_nack,
  output logic       pec_err
);
  import smbt_pkg::*;

  localparam int         BIW       = (NB > 1) ? $clog2(NB) : 1;
  localparam int         WIW       = (NW > 1) ? $clog2(NW) : 1;
  localparam int         IW        = $clog2(BLK_MAX);
  localparam int         LW        = $clog2(BLK_MAX + 1);
  localparam int         CW        = $clog2(BLK_MAX + 3);
  localparam logic [7:0] CMD_WBASE = 8'h40;
  localparam logic [7:0] CMD_BLK   = 8'h80;

  function automatic smbt_class_e decode(input logic [7:0] c);
    if (c[7:6] == 2'b00 && {2'b00, c[5:0]} < 8'(NB))        return CL_BYTE;
    if (c[7:6] == CMD_WBASE[7:6] && {2'b00, c[5:0]} < 8'(NW)) return CL_WORD;
    if (c == CMD_BLK)                                        return CL_BLOCK;
    return CL_BAD;
  endfunction

  smbt_state_e st;
  logic [7:0]  ptr;
  logic [CW-1:0] widx, wlen, ridx;
  logic        pec_ok, err;
  logic [15:0] pend;

  smbt_class_e   cls;
  logic [CW-1:0] wexp, rlen, tx_total;
  logic          data_done, cmd_ok, take_data, take_pec, pec_bad;
  logic [7:0]    crc, b_q, blk_rd;
  logic [15:0]   w_q;
  logic [LW-1:0] blk_len;
  logic          commit_go;

  assign cls = decode(ptr);

  always_comb begin
    unique case (cls)
      CL_BYTE:  begin wexp = CW'(1); rlen = CW'(1); end
      CL_WORD:  begin wexp = CW'(2); rlen = CW'(2); end
      CL_BLOCK: begin wexp = wlen;   rlen = CW'(blk_len) + CW'(1); end
      default:  begin wexp = '0;     rlen = '0; end
    endcase
  end

  assign data_done = (cls == CL_BLOCK) ? (widx != '0 && widx == wlen) : (widx == wexp);

  // Same-cycle ACK decision for a received byte
  always_comb begin
    cmd_ok    = 1'b0;
    take_data = 1'b0;
    take_pec  = 1'b0;
    pec_bad   = 1'b0;
    if (rx_valid) begin
      unique case (st)
        ST_CMD: cmd_ok = (decode(rx_data) != CL_BAD);
        ST_WR: begin
          if (cls == CL_BLOCK && widx == '0) begin
            take_data = (rx_data != 8'h00) && (rx_data <= 8'(BLK_MAX));
          end else if (!data_done) begin
            take_data = 1'b1;
          end else if (pec_en && !pec_ok) begin
            take_pec = (rx_data == crc);
            pec_bad  = !take_pec;
          end
        end
        default: ;
      endcase
    end
  end

  assign rx_ack = cmd_ok | take_data | take_pec;

  assign commit_go = (ev_stop || ev_start) && (st == ST_WR) && data_done &&
                     (ev_start || !pec_en || pec_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ptr    <= '0;
      widx   <= '0;
      wlen   <= '0;
      ridx   <= '0;
      pec_ok <= 1'b0;
      err    <= 1'b0;
      pend   <= '0;
    end else if (ev_stop) begin
      st <= ST_IDLE;
      if (st == ST_WR && data_done && pec_en && !pec_ok) err <= 1'b1;
    end else if (ev_start) begin
      ridx <= '0;
      st   <= ev_rd ? ST_RD : ST_CMD;
    end else begin
      if (rx_valid) begin
        unique case (st)
          ST_CMD: begin
            if (cmd_ok) begin
              ptr    <= rx_data;
              widx   <= '0;
              pec_ok <= 1'b0;
              st     <= ST_WR;
            end else begin
              st <= ST_DEAD;
            end
          end
          ST_WR: begin
            if (take_data) begin
              widx <= widx + CW'(1);
              if (cls == CL_BLOCK && widx == '0) wlen <= CW'(rx_data) + CW'(1);
              if (widx == '0) pend[7:0]  <= rx_data;
              else            pend[15:8] <= rx_data;
            end else if (take_pec) begin
              pec_ok <= 1'b1;
            end else begin
              st <= ST_DEAD;
              if (pec_bad) err <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (tx_valid && tx_ready) ridx <= ridx + CW'(1);
      if (mst_nack && st == ST_RD) st <= ST_DEAD;
    end
  end

  // Read byte selection
  assign tx_total = rlen + (pec_en ? CW'(1) : CW'(0));
  assign tx_valid = (st == ST_RD) && (ridx < tx_total);

  always_comb begin
    if (ridx == rlen) begin
      tx_data = crc;
    end else begin
      unique case (cls)
        CL_BYTE:  tx_data = b_q;
        CL_WORD:  tx_data = (ridx == '0) ? w_q[7:0] : w_q[15:8];
        CL_BLOCK: tx_data = (ridx == '0) ? 8'(blk_len) : blk_rd;
        default:  tx_data = 8'h00;
      endcase
    end
  end

  assign pec_err = err;

  smbt_pec u_pec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_stop),
    .upd   (ev_start || (rx_valid && rx_ack) || (tx_valid && tx_ready)),
    .din   (ev_start ? {DEV_ADDR, ev_rd} : (rx_valid ? rx_data : tx_data)),
    .crc   (crc)
  );

  smbt_regbank #(.NB(NB), .NW(NW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_b  (commit_go && cls == CL_BYTE),
    .wr_w  (commit_go && cls == CL_WORD),
    .b_idx (ptr[BIW-1:0]),
    .w_idx (ptr[WIW-1:0]),
    .wdata (pend),
    .b_q   (b_q),
    .w_q   (w_q)
  );

  smbt_blkbuf #(.MAXLEN(BLK_MAX)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (take_data && st == ST_WR && cls == CL_BLOCK && widx != '0),
    .wr_idx     (IW'(widx - CW'(1))),
    .wr_data    (rx_data),
    .commit     (commit_go && cls == CL_BLOCK),
    .commit_len (LW'(wlen - CW'(1))),
    .rd_idx     (IW'(ridx - CW'(1))),
    .rd_data    (blk_rd),
    .rd_len     (blk_len)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ev_start && !ev_stop && !mst_nack) |=>
      (tx_valid && $stable(tx_data))); // R10

  AST_NACK_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_nack && !ev_start) |=> !tx_valid); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err |=> pec_err); // R9

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && st == ST_CMD) |=> $stable(ptr)); // R2

endmodule

// File: tb/smbt_target_tb.sv
`timescale 1ns/1ps
module smbt_target_tb;

  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, pec_en = 1'b0;
  logic ev_start = 0, ev_rd = 0, ev_stop = 0, rx_valid = 0, tx_ready = 0, mst_nack = 0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ack, tx_valid, pec_err;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  smbt_target u_dut (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en),
    .ev_start(ev_start), .ev_rd(ev_rd), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mst_nack(mst_nack), .pec_err(pec_err)
  );

  int n_cmp = 0, n_bad = 0;
  string req = "R11";

  // Reference model state: 0 idle, 1 command, 2 write, 3 read, 4 ignore
  logic [7:0]  m_breg [8];
  logic [15:0] m_wreg [4];
  logic [7:0]  m_blk  [32];
  int          m_blen = 0;
  logic [7:0]  m_ptr = 8'h00;
  int          m_st = 0;
  logic [7:0]  m_crc = 8'h00;
  bit          m_pecok = 0, m_err = 0;
  logic [7:0]  wq[$];
  logic [7:0]  rdq[$];

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  function automatic int kind(input logic [7:0] c);
    if (c <= 8'h07) return 0;
    if (c >= 8'h40 && c <= 8'h43) return 1;
    if (c == 8'h80) return 2;
    return 3;
  endfunction

  function automatic bit wr_done();
    int k = kind(m_ptr);
    if (k == 2) return wq.size() >= 1 && wq.size() == int'(wq[0]) + 1;
    return wq.size() == ((k == 0) ? 1 : 2);
  endfunction

  task automatic m_commit();
    int k = kind(m_ptr);
    if (k == 0) m_breg[m_ptr[2:0]] = wq[0];
    else if (k == 1) m_wreg[m_ptr[1:0]] = {wq[1], wq[0]};
    else begin
      m_blen = int'(wq[0]);
      for (int i = 0; i < m_blen; i++) m_blk[i] = wq[i+1];
    end
  endtask

  task automatic m_start(input bit rd);
    if (m_st == 2 && wr_done()) m_commit();
    m_crc = crc8(m_crc, {ADDR, rd});
    if (rd) begin
      int k = kind(m_ptr);
      rdq.delete();
      if (k == 0) rdq.push_back(m_breg[m_ptr[2:0]]);
      else if (k == 1) begin
        rdq.push_back(m_wreg[m_ptr[1:0]][7:0]);
        rdq.push_back(m_wreg[m_ptr[1:0]][15:8]);
      end else begin
        rdq.push_back(8'(m_blen));
        for (int i = 0; i < m_blen; i++) rdq.push_back(m_blk[i]);
      end
      if (pec_en) begin
        logic [7:0] t = m_crc;
        foreach (rdq[i]) t = crc8(t, rdq[i]);
        rdq.push_back(t);
      end
      m_st = 3;
    end else begin
      m_st = 1;
    end
  endtask

  task automatic m_stop();
    if (m_st == 2 && wr_done()) begin
      if (!pec_en || m_pecok) m_commit();
      else m_err = 1;
    end
    m_st = 0;
    m_crc = 8'h00;
  endtask

  task automatic m_rx(input logic [7:0] b, output bit ack);
    ack = 0;
    if (m_st == 1) begin
      if (kind(b) != 3) begin
        ack = 1; m_ptr = b; m_st = 2; wq.delete(); m_pecok = 0;
      end else m_st = 4;
    end else if (m_st == 2) begin
      int k = kind(m_ptr);
      if (k == 2 && wq.size() == 0) begin
        if (b >= 8'd1 && b <= 8'd32) begin ack = 1; wq.push_back(b); end
        else m_st = 4;
      end else if (!wr_done()) begin
        ack = 1; wq.push_back(b);
      end else if (pec_en && !m_pecok) begin
        if (b == m_crc) begin ack = 1; m_pecok = 1; end
        else begin m_err = 1; m_st = 4; end
      end else m_st = 4;
    end
    if (ack) m_crc = crc8(m_crc, b);
  endtask

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare, then advance the model
  task automatic tick(input bit s, input bit rd, input bit p, input bit rv,
                      input logic [7:0] b, input bit tr, input bit mn);
    bit exp_txv, ack;
    @(negedge clk);
    ev_start = s; ev_rd = rd; ev_stop = p; rx_valid = rv; rx_data = b;
    tx_ready = tr; mst_nack = mn;
    #1;
    exp_txv = (m_st == 3) && (rdq.size() > 0);
    chk("tx_valid", {7'b0, tx_valid}, {7'b0, exp_txv});
    if (exp_txv) chk("tx_data", tx_data, rdq[0]);
    chk("pec_err", {7'b0, pec_err}, {7'b0, m_err});
    if (rv) begin
      m_rx(b, ack);
      chk("rx_ack", {7'b0, rx_ack}, {7'b0, ack});
    end
    if (s) m_start(rd);
    if (p) m_stop();
    if (tr && exp_txv) begin
      m_crc = crc8(m_crc, rdq[0]);
      void'(rdq.pop_front());
    end
    if (mn && m_st == 3) begin m_st = 4; rdq.delete(); end
  endtask

  task automatic start(input bit rd); tick(1, rd, 0, 0, 8'h00, 0, 0); endtask
  task automatic stop();              tick(0, 0, 1, 0, 8'h00, 0, 0); endtask
  task automatic send(input logic [7:0] b); tick(0, 0, 0, 1, b, 0, 0); endtask
  task automatic take();              tick(0, 0, 0, 0, 8'h00, 1, 0); endtask
  task automatic nack();              tick(0, 0, 0, 0, 8'h00, 0, 1); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) take();
    nack(); stop();
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_breg[i] = 8'h00;
    for (int i = 0; i < 4; i++) m_wreg[i] = 16'h0000;
    for (int i = 0; i < 32; i++) m_blk[i] = 8'h00;

    req = "R11 reset"; idle(3);
    rst_n = 1'b1; idle(2);
    req = "R11 R2 read after reset"; start(1); read_n(2);

    req = "R1 byte write"; start(0); send(8'h03); send(8'hA5); stop();
    req = "R6 command then read"; start(0); send(8'h03); start(1); read_n(1);
    req = "R2 receive byte"; start(1); read_n(1);
    req = "R1 bad command"; start(0); send(8'h20); send(8'h11); stop();
    req = "R2 pointer kept"; start(1); read_n(1);

    req = "R3 word write"; start(0); send(8'h41); send(8'hEF); send(8'hBE); stop();
    req = "R3 word read"; start(0); send(8'h41); start(1); read_n(2);

    req = "R5 block write"; start(0); send(8'h80); send(8'h03);
    send(8'h11); send(8'h22); send(8'h33); stop();
    req = "R4 block read"; start(0); send(8'h80); start(1); read_n(4);
    req = "R5 count too big"; start(0); send(8'h80); send(8'd33); send(8'h44); stop();
    req = "R5 count zero"; start(0); send(8'h80); send(8'h00); stop();
    req = "R4 block unchanged"; start(1); read_n(4);

    req = "R7 extra byte"; start(0); send(8'h02); send(8'h5C); send(8'h99); stop();
    req = "R7 discarded"; start(0); send(8'h02); start(1); read_n(1);
    req = "R7 no data"; start(0); send(8'h04); stop(); start(1); read_n(1);

    req = "R6 process call"; start(0); send(8'h42); send(8'h34); send(8'h12);
    start(1); read_n(2);

    req = "R10 back-pressure"; start(0); send(8'h41); start(1);
    idle(3); take(); idle(2); take(); idle(2); nack(); stop();
    req = "R10 master nack"; start(0); send(8'h41); start(1);
    take(); nack(); take(); send(8'h55); idle(2); stop();

    pec_en = 1'b1; idle(1);
    req = "R8 write with pec"; start(0); send(8'h05); send(8'h5A); send(m_crc); stop();
    req = "R8 read with pec"; start(0); send(8'h05); start(1); read_n(2);
    req = "R8 word read with pec"; start(1); read_n(0); start(0); send(8'h42);
    start(1); read_n(3);
    req = "R8 block read with pec"; start(0); send(8'h80); start(1); read_n(5);
    req = "R9 wrong pec"; start(0); send(8'h05); send(8'h77); send(m_crc ^ 8'h01); stop();
    req = "R9 discarded"; start(0); send(8'h05); start(1); read_n(2);
    req = "R9 missing pec"; start(0); send(8'h06); send(8'h66); stop();
    req = "R9 still old"; start(0); send(8'h06); start(1); read_n(2);
    req = "R9 sticky"; pec_en = 1'b0; idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule